// File: doc/BRIEF.md
# Coherent Split-Register ADC Readback

This block is a read-only register bank. It presents six 10-bit conversion results to software over a byte-wide register bus. A conversion engine pushes each new result with a single-cycle valid pulse and a channel index. The bank keeps the latest word for every channel. Software reads each result through two byte addresses: one odd address for the upper eight bits and one even address for the lower two bits.

A 10-bit result can only be read as two bytes, and the converter may finish a new conversion between those two reads. A read of the upper byte therefore also copies that channel's two low bits into one holding register. All channels share this register. A later read of any low-byte address returns the holding register, not the live bits, so a high-then-low sequence always gives a matched pair. Software that needs only 8 bits reads the upper byte alone. Reads have no effect on the stored results or on the engine.

Read data is registered. The byte for a read strobe in cycle N appears on `rd_data` after the clock edge that ends cycle N, and it holds there until the next strobe.

Top module: `adc_readback_bank`

## Requirements
- R1: For channel k (0..5), the low-part byte is at address 0x08+2k and the high-part byte is at address 0x09+2k, so the pairs run from 0x08/0x09 to 0x12/0x13.
- R2: A read of a high-part address puts result bits [9:2] of that channel on `rd_data` in bit positions 7:0 one clock after the strobe.
- R3: A high-part read copies result bits [1:0] of that channel into the shared holding register at the same clock edge.
- R4: A read of a low-part address returns the holding register in bit positions 1:0 and zero in bit positions 7:2. It never returns the live low bits of the addressed channel.
- R5: There is one holding register for all channels. A low-part read at any channel's address returns the bits latched by the most recent high-part read of any channel.
- R6: When `upd_valid` is high and `upd_chan` is below 6, the result of that channel is replaced by `upd_data`. Indices 6 and 7 are ignored, and reads never change a stored result.
- R7: When an update and a high-part read of the same channel fall in one cycle, the read and the holding register take the old value. The new value is returned by the next read.
- R8: After reset, every result register, the holding register and `rd_data` are zero.
- R9: A read of an address outside 0x08..0x13 returns 0x00 and leaves the holding register unchanged.
- R10: In a cycle without a read strobe, `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Single-cycle pulse marking a new conversion result |
| upd_chan | input | 3 | Channel index of the new result |
| upd_data | input | 10 | New conversion result |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Register address of the read |
| rd_data | output | 8 | Registered read data, valid from one clock after the strobe |

## Verification
A corrupted holding register does not show up on a high-byte read. It appears only at the next low-byte read, which may come many cycles later and may use another channel's address. The bench therefore reads high-then-low pairs across different channels and tests low reads after unmapped reads and idle gaps. A wrong result register or a decode error shows up on the very next read of the affected byte. A reference model checks every cycle, so any wrong value is reported in the cycle after the strobe that exposes it.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_LO   = 2'd1,
      ACC_HI   = 2'd2,
      ACC_MISS = 2'd3
   } acc_kind_e;
endpackage

// File: rtl/adc_rb_decode.sv
module adc_rb_decode
   import adc_rb_pkg::*;
#(
   parameter int NCH    = 6,
   parameter int ADDR_W = 8,
   parameter int CH_W   = 3,
   parameter logic [ADDR_W-1:0] BASE = 8'h08
) (
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output acc_kind_e         kind,
   output logic [CH_W-1:0]   chan
);
   localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(2 * NCH);

   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] half;

   assign offset = rd_addr - BASE;
   assign half   = offset >> 1;
   assign chan   = half[CH_W-1:0];

   always_comb begin
      if (!rd_en)
         kind = ACC_NONE;
      else if (rd_addr >= BASE && offset < SPAN)
         kind = offset[0] ? ACC_HI : ACC_LO;
      else
         kind = ACC_MISS;
   end
endmodule

// File: rtl/adc_rb_results.sv
module adc_rb_results #(
   parameter int NCH   = 6,
   parameter int RES_W = 10,
   parameter int CH_W  = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       upd_valid,
   input  logic [CH_W-1:0]            upd_chan,
   input  logic [RES_W-1:0]           upd_data,
   output logic [NCH-1:0][RES_W-1:0]  res
);
   for (genvar g = 0; g < NCH; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            res[g] <= '0;
         else if (upd_valid && upd_chan == CH_W'(g))
            res[g] <= upd_data;
      end
   end
endmodule

// File: rtl/adc_rb_hold.sv
module adc_rb_hold #(
   parameter int LO_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [LO_W-1:0] din,
   output logic [LO_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (load)
         q <= din;
   end
endmodule

// File: rtl/adc_readback_bank.sv
module adc_readback_bank
   import adc_rb_pkg::*;
#(
   parameter int NCH    = 6,
   parameter int RES_W  = 10,
   parameter int LO_W   = 2,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] BASE = 8'h08,
   localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  logic [CH_W-1:0]   upd_chan,
   input  logic [RES_W-1:0]  upd_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   if (RES_W != DATA_W + LO_W) begin : g_bad_split
      $error("RES_W must equal DATA_W + LO_W");
   end
   if (LO_W < 1 || LO_W >= DATA_W) begin : g_bad_lo
      $error("LO_W must be in 1..DATA_W-1");
   end
   if (CH_W > ADDR_W) begin : g_bad_addr
      $error("address too narrow for channel count");
   end

   acc_kind_e                acc;
   logic [CH_W-1:0]          rd_chan;
   logic [NCH-1:0][RES_W-1:0] res;
   logic [RES_W-1:0]         sel;
   logic [LO_W-1:0]          hold_q;

   adc_rb_decode #(
      .NCH(NCH), .ADDR_W(ADDR_W), .CH_W(CH_W), .BASE(BASE)
   ) u_dec (
      .rd_en(rd_en), .rd_addr(rd_addr), .kind(acc), .chan(rd_chan)
   );

   adc_rb_results #(
      .NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)
   ) u_res (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid),
      .upd_chan(upd_chan), .upd_data(upd_data), .res(res)
   );

   always_comb begin
      sel = '0;
      for (int i = 0; i < NCH; i++)
         if (rd_chan == CH_W'(i)) sel = res[i];
   end

   adc_rb_hold #(
      .LO_W(LO_W)
   ) u_hold (
      .clk(clk), .rst_n(rst_n), .load(acc == ACC_HI),
      .din(sel[LO_W-1:0]), .q(hold_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else begin
         case (acc)
            ACC_HI:   rd_data <= sel[RES_W-1:LO_W];
            ACC_LO:   rd_data <= {{(DATA_W-LO_W){1'b0}}, hold_q};
            ACC_MISS: rd_data <= '0;
            default:  rd_data <= rd_data;
         endcase
      end
   end
endmodule

// File: rtl/adc_rb_checker.sv
module adc_rb_checker #(
   parameter int NCH    = 6,
   parameter int LO_W   = 2,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] BASE = 8'h08
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic [LO_W-1:0]   hold_q,
   input logic [1:0]        acc
);
   int   off;
   logic in_rng;
   logic odd;

   assign off    = int'(rd_addr) - int'(BASE);
   assign in_rng = (off >= 0) && (off < 2 * NCH);
   assign odd    = off[0];

   // R1: an odd in-range address decodes as a high-part access
   a_r1_hi_decode: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && in_rng && odd) |-> (acc == 2'd2));

   // R4: low-part byte has zero padding above the held bits
   a_r4_lo_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && in_rng && !odd) |=> (rd_data[DATA_W-1:LO_W] == '0));

   // R9: unmapped reads return zero
   a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !in_rng) |=> (rd_data == '0));

   // R3: holding register changes only on a high-part read
   a_r3_hold_only_hi: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && in_rng && odd) |=> $stable(hold_q));

   // R10: read data held while idle
   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));
endmodule

bind adc_readback_bank adc_rb_checker #(
   .NCH(NCH), .LO_W(LO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
   .rd_data(rd_data), .hold_q(hold_q), .acc(acc)
);

// File: tb/tb_adc_readback_bank.sv
module tb_adc_readback_bank;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       upd_valid = 1'b0;
   logic [2:0] upd_chan = '0;
   logic [9:0] upd_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;

   int n_chk = 0;
   int n_fail = 0;

   adc_readback_bank dut (
      .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_chan(upd_chan),
      .upd_data(upd_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   always #5 clk = ~clk;

   // behavioural reference model
   int    m_res[6];
   int    m_hold;
   int    m_rd;
   string m_tag = "R8";
   int    m_off;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         foreach (m_res[i]) m_res[i] = 0;
         m_hold = 0; m_rd = 0; m_tag = "R8";
      end else begin
         m_off = int'(rd_addr) - 8;
         if (rd_en) begin
            if (m_off >= 0 && m_off < 12) begin
               if (m_off % 2 == 1) begin
                  m_rd = m_res[m_off/2] >> 2;
                  m_hold = m_res[m_off/2] & 3;
                  m_tag = "R2";
               end else begin
                  m_rd = m_hold;
                  m_tag = "R4";
               end
            end else begin
               m_rd = 0;
               m_tag = "R9";
            end
         end else
            m_tag = "R10";
         if (upd_valid && upd_chan < 6) m_res[upd_chan] = int'(upd_data); // R6, R7
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_chk++;
         if (int'(rd_data) != m_rd) begin
            n_fail++;
            $display("FAIL %s model: rd_data=%02h expected=%02h", m_tag, rd_data, m_rd[7:0]);
         end
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a);
      @(negedge clk); rd_en = 1'b1; rd_addr = a;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic upd(input logic [2:0] c, input logic [9:0] d);
      @(negedge clk); upd_valid = 1'b1; upd_chan = c; upd_data = d;
      @(negedge clk); upd_valid = 1'b0;
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R8", rd_data, 8'h00);
      rst_n = 1'b1;
      rd(8'h09); chk("R8", rd_data, 8'h00);
      rd(8'h08); chk("R8", rd_data, 8'h00);
      // R6: out-of-range channel indices are ignored
      upd(3'd6, 10'h3FF); upd(3'd7, 10'h3FF);
      for (int k = 0; k < 6; k++) begin
         rd(8'(9 + 2*k)); chk("R6", rd_data, 8'h00);
      end
      upd(3'd0, 10'h3FF); upd(3'd5, 10'h2A7);
      rd(8'h09); chk("R2", rd_data, 8'hFF);
      rd(8'h08); chk("R3", rd_data, 8'h03);
      rd(8'h13); chk("R1", rd_data, 8'hA9);
      rd(8'h12); chk("R1", rd_data, 8'h03);
      // R4: live low bits change, low read still shows held bits
      upd(3'd5, 10'h2A4);
      rd(8'h12); chk("R4", rd_data, 8'h03);
      // R5: shared holding register across channels
      upd(3'd1, 10'h001);
      rd(8'h0B); chk("R5", rd_data, 8'h00);
      rd(8'h08); chk("R5", rd_data, 8'h01);
      // R7: update and high read of channel 2 in one cycle
      @(negedge clk); rd_en = 1'b1; rd_addr = 8'h0D;
      upd_valid = 1'b1; upd_chan = 3'd2; upd_data = 10'h3FE;
      @(negedge clk); rd_en = 1'b0; upd_valid = 1'b0;
      chk("R7", rd_data, 8'h00);
      rd(8'h0C); chk("R7", rd_data, 8'h00);
      rd(8'h0D); chk("R7", rd_data, 8'hFF);
      rd(8'h0C); chk("R7", rd_data, 8'h02);
      // R9: unmapped reads
      rd(8'h07); chk("R9", rd_data, 8'h00);
      rd(8'h15); chk("R9", rd_data, 8'h00);
      rd(8'hFF); chk("R9", rd_data, 8'h00);
      rd(8'h10); chk("R9", rd_data, 8'h02);
      // R10: idle keeps data
      rd(8'h0D);
      repeat (5) @(negedge clk);
      chk("R10", rd_data, 8'hFF);
      // mixed traffic, compared each cycle by the model
      for (int n = 0; n < 4000; n++) begin
         @(negedge clk);
         rd_en = ($urandom % 3) != 0;
         rd_addr = ($urandom % 4 == 0) ? 8'($urandom) : 8'(6 + $urandom % 16);
         upd_valid = ($urandom % 2) != 0;
         upd_chan = 3'($urandom);
         upd_data = 10'($urandom);
      end
      @(negedge clk); rd_en = 1'b0; upd_valid = 1'b0;
      @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule